// File: doc/BRIEF.md
# Watermark Write-Drain Request Scheduler

This block takes memory requests for a single bank and keeps reads and writes in two separate queues. Each cycle it offers one bank command on a grant output, and the downstream bank logic consumes it by raising its ready input. Every request carries an address. The upper bits form the row, and the lower bits form the column.

Reads are normally served first. Writes pile up until their queue is completely full. The scheduler then switches into a write-drain mode and serves only writes, until the write queue has shrunk to the low watermark.

Within whichever queue is active, the scheduler picks in two steps:
- A request whose row matches the currently open row gets its column command first.
- If no request matches, the oldest request is used. The scheduler closes the open row with a precharge, then opens the new row with an activate.

Rows stay open between requests, and a row is closed only when a miss forces it.

Top module: `wds_sched`

## Requirements
- R1: After reset no grant is offered, `req_rdy` is high, `drain_mode` is low and no row is open.
- R2: `req_rdy` is low exactly when the queue selected by `req_wr` (1 = write, 0 = read) holds 32 entries. A request with `req_vld` and `req_rdy` high on a rising edge is appended to that queue.
- R3: Write-drain mode (`drain_mode` high) begins on the cycle after one in which the write queue holds 32 entries. While it lasts, no read command is granted.
- R4: Write-drain mode ends on the cycle after one in which the write queue holds 16 or fewer entries.
- R5: Outside drain mode, the read queue is served whenever it is non-empty. Writes are granted only while the read queue is empty.
- R6: If a row is open and the active queue holds requests to that row, the oldest such request receives a column command (`gnt_cmd` 2 = read, 3 = write). It is removed from its queue when the command is consumed.
- R7: If a row is open and no request in the active queue hits it, the grant is a precharge (`gnt_cmd` 0) carrying the open row. Consuming it closes the row.
- R8: If no row is open, the grant is an activate (`gnt_cmd` 1) for the oldest request's row. Consuming it opens that row.
- R9: A grant is consumed only on a rising edge with `bank_rdy` high. With `bank_rdy` low and no new requests, the offered command, row and column stay unchanged.
- R10: With both queues empty, `gnt_vld` is low and the open row stays open.
- R11: Addresses split as row = `addr[15:6]` and column = `addr[5:0]`. `gnt_row` and `gnt_col` carry the chosen request's fields, except that a precharge carries the open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | Request type: 1 write, 0 read |
| req_addr | input | 16 | Request address (row high, column low) |
| req_rdy | output | 1 | Queue for the presented type can accept |
| bank_rdy | input | 1 | Bank logic consumes the offered command this cycle |
| gnt_vld | output | 1 | A command is offered |
| gnt_cmd | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| gnt_row | output | 10 | Row of the command |
| gnt_col | output | 6 | Column of the chosen request |
| drain_mode | output | 1 | Write-drain mode active |

## Verification
The queue assertions assume the block's edge is only pushed when `req_rdy` allows. They also assume entries are popped only from filled slots.

The stimulus respects the handshake by driving `req_vld` freely, while the reference model appends a request only when it computes that the targeted queue is not full.

The bank is modelled as ready with random gaps. Addresses are drawn from a handful of rows, so row hits, misses and full queues all occur. Directed runs fill the write queue against a stalled bank to force the drain entry and exit.

// File: rtl/wds_pkg.sv
`timescale 1ns/1ps
package wds_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } bank_cmd_e;
endpackage

// File: rtl/wds_rst_sync.sv
`timescale 1ns/1ps
module wds_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/wds_queue.sv
`timescale 1ns/1ps
// Collapsing request queue: slot 0 is always the oldest entry.
module wds_queue #(
  parameter int DEPTH = 32,
  parameter int AW    = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [AW-1:0]                 push_addr,
  input  logic                          pop,
  input  logic [IDX_W-1:0]              pop_idx,
  output logic [CNT_W-1:0]              cnt_o,
  output logic [DEPTH-1:0][AW-1:0]      ent_o
);
  logic [CNT_W-1:0]         cnt_q, cnt_mid, cnt_n;
  logic [DEPTH-1:0][AW-1:0] ent_q, ent_n;
  logic                     upd_en;

  assign upd_en = push | pop;

  always_comb begin
    ent_n   = ent_q;
    cnt_mid = pop ? (cnt_q - CNT_W'(1)) : cnt_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx) ent_n[i] = ent_q[i+1];
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (CNT_W'(i) == cnt_mid)) ent_n[i] = push_addr;
    end
    cnt_n = cnt_mid + (push ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (upd_en) ent_q <= ent_n;
  end

  assign cnt_o = cnt_q;
  assign ent_o = ent_q;

  // R2: the edge handshake never pushes into a full queue
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));

  // R6: a column command removes only an occupied slot
  p_pop_occupied_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CNT_W'(pop_idx) < cnt_q));
endmodule

// File: rtl/wds_hit_pick.sv
`timescale 1ns/1ps
// Finds the oldest queued entry whose row matches the open row.
module wds_hit_pick #(
  parameter int DEPTH = 32,
  parameter int AW    = 16,
  parameter int CW    = 6,
  localparam int RW    = AW - CW,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][AW-1:0] ent,
  input  logic [CNT_W-1:0]         cnt,
  input  logic                     row_open,
  input  logic [RW-1:0]            open_row,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (row_open && (CNT_W'(i) < cnt) && (ent[i][AW-1:CW] == open_row)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wds_sched.sv
`timescale 1ns/1ps
module wds_sched #(
  parameter int DEPTH    = 32,
  parameter int LOW_MARK = 16,
  parameter int AW       = 16,
  parameter int CW       = 6,
  localparam int RW    = AW - CW,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  output logic          req_rdy,
  input  logic          bank_rdy,
  output logic          gnt_vld,
  output logic [1:0]    gnt_cmd,
  output logic [RW-1:0] gnt_row,
  output logic [CW-1:0] gnt_col,
  output logic          drain_mode
);
  import wds_pkg::*;

  logic                                srst_n;
  logic [1:0]                          q_push, q_pop;
  logic [1:0][CNT_W-1:0]               q_cnt;
  logic [1:0][DEPTH-1:0][AW-1:0]       q_ent;
  logic [1:0]                          q_hit;
  logic [1:0][IDX_W-1:0]               q_hidx;

  logic            row_open_q, row_open_n;
  logic [RW-1:0]   open_row_q, open_row_n;
  logic            drain_q, drain_n;

  logic            sel_wr, sel_any, cand_hit, issue;
  logic [IDX_W-1:0] cand_idx;
  logic [AW-1:0]   cand;
  bank_cmd_e       cmd;

  wds_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign req_rdy = req_wr ? (q_cnt[1] != CNT_W'(DEPTH))
                          : (q_cnt[0] != CNT_W'(DEPTH));

  // index 0 holds reads, index 1 holds writes
  for (genvar g = 0; g < 2; g++) begin : g_q
    assign q_push[g] = req_vld && req_rdy && (req_wr == (g == 1));

    wds_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
      .clk      (clk),
      .rst_n    (srst_n),
      .push     (q_push[g]),
      .push_addr(req_addr),
      .pop      (q_pop[g]),
      .pop_idx  (q_hidx[g]),
      .cnt_o    (q_cnt[g]),
      .ent_o    (q_ent[g])
    );

    wds_hit_pick #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_pick (
      .ent     (q_ent[g]),
      .cnt     (q_cnt[g]),
      .row_open(row_open_q),
      .open_row(open_row_q),
      .hit     (q_hit[g]),
      .hit_idx (q_hidx[g])
    );
  end

  // queue selection by mode
  always_comb begin
    if (drain_q) begin
      sel_wr  = 1'b1;
      sel_any = (q_cnt[1] != '0);
    end else if (q_cnt[0] != '0) begin
      sel_wr  = 1'b0;
      sel_any = 1'b1;
    end else begin
      sel_wr  = 1'b1;
      sel_any = (q_cnt[1] != '0);
    end
  end

  // command choice for the selected queue
  always_comb begin
    cand_hit = q_hit[sel_wr];
    cand_idx = cand_hit ? q_hidx[sel_wr] : '0;
    cand     = q_ent[sel_wr][cand_idx];
    if (cand_hit)        cmd = sel_wr ? CMD_WR : CMD_RD;
    else if (row_open_q) cmd = CMD_PRE;
    else                 cmd = CMD_ACT;
    issue = sel_any && bank_rdy;
    q_pop = '0;
    if (issue && cand_hit) q_pop[sel_wr] = 1'b1;
  end

  // row state and drain mode next-state
  always_comb begin
    row_open_n = row_open_q;
    open_row_n = open_row_q;
    if (issue && (cmd == CMD_PRE)) row_open_n = 1'b0;
    if (issue && (cmd == CMD_ACT)) begin
      row_open_n = 1'b1;
      open_row_n = cand[AW-1:CW];
    end
    drain_n = drain_q ? (q_cnt[1] > CNT_W'(LOW_MARK))
                      : (q_cnt[1] == CNT_W'(DEPTH));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      row_open_q <= 1'b0;
      open_row_q <= '0;
    end else if (issue) begin
      row_open_q <= row_open_n;
      open_row_q <= open_row_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) drain_q <= 1'b0;
    else         drain_q <= drain_n;
  end

  assign gnt_vld    = sel_any;
  assign gnt_cmd    = cmd;
  assign gnt_row    = (cmd == CMD_PRE) ? open_row_q : cand[AW-1:CW];
  assign gnt_col    = cand[CW-1:0];
  assign drain_mode = drain_q;

  // R3: no read command while draining writes
  p_drain_no_read_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (drain_mode && gnt_vld) |-> (gnt_cmd != CMD_RD));

  // R4: one pop per cycle keeps the drain from undershooting the low mark
  p_drain_floor_r4: assert property (@(posedge clk) disable iff (!srst_n)
    drain_mode |-> (q_cnt[1] >= CNT_W'(LOW_MARK)));

  // R5: outside drain, waiting reads block write commands
  p_read_first_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (gnt_vld && !drain_mode && (q_cnt[0] != '0)) |-> (gnt_cmd != CMD_WR));

  // R7: a consumed precharge closes the row
  p_pre_closes_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (gnt_vld && bank_rdy && (gnt_cmd == CMD_PRE)) |=> !row_open_q);

  // R8: a consumed activate opens the granted row
  p_act_opens_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (gnt_vld && bank_rdy && (gnt_cmd == CMD_ACT)) |=>
      (row_open_q && (open_row_q == $past(gnt_row))));

  // R10: empty queues offer nothing
  p_idle_r10: assert property (@(posedge clk) disable iff (!srst_n)
    ((q_cnt[0] == '0) && (q_cnt[1] == '0)) |-> !gnt_vld);
endmodule

// File: tb/wds_sched_test.sv
`timescale 1ns/1ps
module wds_sched_test;
  localparam int DEPTH = 32;
  localparam int LOWM  = 16;

  logic        clk = 1'b0;
  logic        rst_n, req_vld, req_wr, req_rdy, bank_rdy;
  logic [15:0] req_addr;
  logic        gnt_vld, drain_mode;
  logic [1:0]  gnt_cmd;
  logic [9:0]  gnt_row;
  logic [5:0]  gnt_col;

  always #2 clk = ~clk;

  wds_sched uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_rdy(req_rdy), .bank_rdy(bank_rdy),
    .gnt_vld(gnt_vld), .gnt_cmd(gnt_cmd), .gnt_row(gnt_row),
    .gnt_col(gnt_col), .drain_mode(drain_mode)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mq [2][DEPTH];
  int          mcnt [2];
  bit          mdrain, mopen;
  logic [9:0]  mrow;

  // expected grant
  bit          e_any;
  int          e_sel, e_hit, e_idx;
  logic [1:0]  e_cmd;
  logic [9:0]  e_row;
  logic [5:0]  e_col;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] rowf(input logic [15:0] a);
    return a[15:6]; // R11 row field
  endfunction

  task automatic expect_grant();
    logic [15:0] a;
    if (mdrain)            begin e_sel = 1; e_any = (mcnt[1] > 0); end
    else if (mcnt[0] > 0)  begin e_sel = 0; e_any = 1; end
    else                   begin e_sel = 1; e_any = (mcnt[1] > 0); end
    e_hit = -1;
    if (mopen)
      for (int i = 0; i < mcnt[e_sel]; i++)
        if (e_hit < 0 && rowf(mq[e_sel][i]) == mrow) e_hit = i;
    e_idx = (e_hit >= 0) ? e_hit : 0;
    a = mq[e_sel][e_idx];
    if (e_hit >= 0) e_cmd = (e_sel == 1) ? 2'd3 : 2'd2;
    else            e_cmd = mopen ? 2'd0 : 2'd1;
    e_row = (e_cmd == 2'd0) ? mrow : rowf(a);
    e_col = a[5:0];
  endtask

  task automatic cyc(input bit v, input bit w, input logic [15:0] a, input bit br);
    bit exp_rdy;
    int wc_before;
    @(negedge clk);
    req_vld = v; req_wr = w; req_addr = a; bank_rdy = br;
    #1;
    expect_grant();
    exp_rdy = (mcnt[w] < DEPTH);
    chk("R2 req_rdy", req_rdy, exp_rdy);
    chk(mdrain ? "R3 drain" : "R4 drain", drain_mode, mdrain);
    chk(e_any ? "R5 gnt_vld" : "R10 gnt_vld", gnt_vld, e_any);
    if (e_any) begin
      case (e_cmd)
        2'd0:    chk("R7 cmd", gnt_cmd, e_cmd);
        2'd1:    chk("R8 cmd", gnt_cmd, e_cmd);
        default: chk("R6 cmd", gnt_cmd, e_cmd);
      endcase
      chk("R11 row", gnt_row, e_row);
      chk("R11 col", gnt_col, e_col);
    end
    // advance the model as the next rising edge will
    wc_before = mcnt[1];
    if (e_any && br) begin
      if (e_hit >= 0) begin
        for (int i = e_idx; i < DEPTH - 1; i++) mq[e_sel][i] = mq[e_sel][i+1];
        mcnt[e_sel]--;
      end else if (e_cmd == 2'd0) mopen = 0;
      else begin mopen = 1; mrow = e_row; end
    end
    mdrain = mdrain ? (wc_before > LOWM) : (wc_before == DEPTH);
    if (v && exp_rdy) begin
      mq[w][mcnt[w]] = a;
      mcnt[w]++;
    end
  endtask

  function automatic logic [15:0] mk(input int r, input int c);
    return {10'(r), 6'(c)};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    rst_n = 0; req_vld = 0; req_wr = 0; req_addr = '0; bank_rdy = 0;
    mcnt[0] = 0; mcnt[1] = 0; mdrain = 0; mopen = 0; mrow = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 gnt_vld", gnt_vld, 0);
    chk("R1 req_rdy", req_rdy, 1);
    chk("R1 drain", drain_mode, 0);

    // R6 R7 R8: hit-first ordering, miss sequence
    cyc(1, 0, mk(5, 1), 0);
    cyc(1, 0, mk(7, 2), 0);
    cyc(1, 0, mk(5, 3), 0);
    repeat (8) cyc(0, 0, '0, 1);

    // R5: writes wait behind reads
    cyc(1, 1, mk(7, 9), 0);
    cyc(1, 0, mk(3, 4), 0);
    cyc(1, 1, mk(3, 8), 0);
    repeat (10) cyc(0, 0, '0, 1);

    // R10: idle, row left open; then a hit on it needs no activate
    repeat (3) cyc(0, 0, '0, 1);
    cyc(1, 0, {mrow, 6'd12}, 0);
    repeat (3) cyc(0, 0, '0, 1);

    // R2 R3: fill the write queue against a stalled bank, one extra refused
    for (int k = 0; k < DEPTH + 1; k++) cyc(1, 1, mk(k % 3, k), 0);
    cyc(1, 0, mk(9, 1), 0);
    cyc(0, 0, '0, 0);
    // R9: stalled bank keeps the offer steady
    #1 held = {20'(0), gnt_cmd, gnt_row};
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, '0, 0);
      chk("R9 hold", {20'(0), gnt_cmd, gnt_row}, held);
    end
    // R4: drain down to the low mark, then reads resume
    repeat (60) cyc(0, 0, '0, 1);

    // random phases
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 2500; k++) begin
        bit v, w, br;
        v  = ($urandom % 4) != 0;
        w  = (p == 0) ? (($urandom % 10) < 8) : (($urandom % 2) == 1);
        br = (p == 0) ? (($urandom % 3) == 0) : (($urandom % 4) != 0);
        cyc(v, w, mk($urandom % 4, $urandom % 64), br);
      end
      repeat (200) cyc(0, 0, '0, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule